// File: doc/BRIEF.md
# Dual-Pointer Address Generation Unit

This unit forms data-memory addresses for a 16-bit signal-processing core. It holds four address pointers, a general offset register, a secondary offset register and a modifier register. Each cycle it accepts one decoded addressing command: a mode code, a pointer select, a raw displacement field and a dual-read flag. It returns the primary effective address combinationally in the same cycle. Any pointer post-update takes effect at the next rising clock edge.

The pointers are not interchangeable. Only pointers 0 and 1 follow the modifier register, which switches their post-updates between linear and circular-buffer arithmetic. The command never selects the arithmetic type. Only pointer 3 can deliver the second address of a dual read, and only pointer 3 accepts a post-update by the secondary offset. Pointers 0 and 1 each have a shadow copy, which is exchanged with the live value when the core enters or leaves a fast interrupt. A register write port and a combinational read port load the registers and observe them.

Top module: `dual_ptr_agu`

## Requirements
- R1: After reset, all four pointers, both offset registers and both shadows read zero, and the modifier reads all ones (linear).
- R2: Mode codes give these primary addresses: 0 indirect = Rn; 1 post-increment, 2 post-decrement, 3 post-add-N and 8 post-add-N3 = Rn; 4 = Rn+N; 5 = Rn plus the low 6 displacement bits sign-extended; 6 = Rn plus the low 16 bits sign-extended; 7 = Rn plus all 24 bits. Sums wrap modulo 2^24. The address output is zero when no valid primary access is issued.
- R3: Modes 1, 2, 3 and 8 issue the old pointer and write the updated value at the next clock edge. Modes 0 and 4 to 7 leave the pointer unchanged.
- R4: Pointer 2 and pointer 3 always update linearly, whatever the modifier holds. Pointers 0 and 1 update linearly while the modifier is all ones.
- R5: For pointer 0 or 1 with modifier value M (not all ones), the buffer holds M+1 words. Its base is the pointer with the bits below the next power of two at or above M+1 cleared. A post-update steps the offset inside the buffer: stepping past base+M wraps to base, stepping below base wraps to base+M. This holds for steps of magnitude up to M+1.
- R6: When the dual flag is set on a valid command, the secondary address equals pointer 3 and the secondary valid is high. Pointer 3 then advances by 1, or by N3 when the step-select input is high. The secondary address output is zero otherwise.
- R7: Mode 8 on pointer 3 issues pointer 3 and then adds N3 to it, linearly.
- R8: Mode 8 on pointers 0 to 2, or any mode code 9 to 15, raises the illegal flag for that cycle. The primary valid is then low, the primary address is zero and no pointer changes through the primary path.
- R9: A dual read that also selects pointer 3 as primary raises the conflict flag. Pointer 3 is then served and updated by the secondary rule only.
- R10: A fast-interrupt entry or exit pulse swaps pointers 0 and 1 with their shadows at the next edge. Any other update to pointers 0 and 1 in that cycle is dropped.
- R11: Write-port codes are 0 to 3 for the pointers, 4 for N, 5 for N3 and 6 for the modifier. A write overrides a command update to the same register in the same cycle. The read port uses the same codes, and code 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_mode | input | 4 | Addressing mode code |
| cmd_sel | input | 2 | Primary pointer select |
| cmd_disp | input | 24 | Raw displacement field |
| cmd_dual | input | 1 | Dual read: second address from pointer 3 |
| sec_step_n3 | input | 1 | Secondary post-step by N3 instead of 1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write code |
| wr_data | input | 24 | Register write value |
| fi_enter | input | 1 | Fast-interrupt entry pulse |
| fi_exit | input | 1 | Fast-interrupt return pulse |
| rd_sel | input | 3 | Register read code |
| rd_data | output | 24 | Register read value |
| ea_pri | output | 24 | Primary effective address |
| ea_pri_valid | output | 1 | Primary address issued |
| ea_sec | output | 24 | Secondary effective address |
| ea_sec_valid | output | 1 | Secondary address issued |
| illegal_mode | output | 1 | Unsupported mode for the selected pointer |
| dual_conflict | output | 1 | Dual read with pointer 3 as primary |

## Verification
All address outputs and flags are combinational, so they are due in the cycle the command is driven. Register contents change one clock edge later and appear on the read port from the following cycle. The bench drives inputs shortly after a rising edge and compares every output roughly 8 ns later, well before the next edge. It then advances its own model state as the edge would, so post-updates, swaps and write overrides are checked on the read port in the cycles that follow. The read select rotates through every code, which compares the full register set against the model continuously.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W = 24;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam logic [3:0] MODE_IND  = 4'd0;
  localparam logic [3:0] MODE_PINC = 4'd1;
  localparam logic [3:0] MODE_PDEC = 4'd2;
  localparam logic [3:0] MODE_PN   = 4'd3;
  localparam logic [3:0] MODE_IDXN = 4'd4;
  localparam logic [3:0] MODE_SHRT = 4'd5;
  localparam logic [3:0] MODE_D16  = 4'd6;
  localparam logic [3:0] MODE_D24  = 4'd7;
  localparam logic [3:0] MODE_PN3  = 4'd8;

  // Sign-extend the low w bits of raw to the full address width.
  function automatic addr_t sext_low(addr_t raw, int w);
    addr_t v;
    v = raw;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= w) v[i] = raw[w-1];
    end
    return v;
  endfunction

  // All bits below the highest set bit of m, plus that bit.
  function automatic addr_t wrap_mask(addr_t m);
    addr_t r;
    r = m;
    for (int i = 0; i < ADDR_W; i++) r = r | (r >> 1);
    return r;
  endfunction

  // Post-update arithmetic: linear add, or offset step inside an M+1 buffer.
  function automatic addr_t ptr_step(addr_t r, addr_t d, logic lin, addr_t m);
    addr_t mask, base;
    logic signed [ADDR_W+1:0] s, lim, sz;
    if (lin) return r + d;
    mask = wrap_mask(m);
    base = r & ~mask;
    lim  = $signed({2'b00, m});
    sz   = lim + 1;
    s    = $signed({2'b00, r & mask}) + $signed({d[ADDR_W-1], d[ADDR_W-1], d});
    if (s > lim) s = s - sz;
    else if (s < 0) s = s + sz;
    return base | s[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int NPTR = 4,
  parameter int NSH  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPTR-1:0]      upd_en,
  input  addr_t [NPTR-1:0]     upd_val,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  addr_t                wr_data,
  input  logic                 swap,
  input  logic [2:0]           rd_sel,
  output addr_t [NPTR-1:0]     ptr_q,
  output addr_t [NSH-1:0]      shd_q,
  output addr_t                n_q,
  output addr_t                n3_q,
  output addr_t                m01_q,
  output addr_t                rd_data
);
  localparam logic [2:0] CODE_N   = 3'(NPTR);
  localparam logic [2:0] CODE_N3  = 3'(NPTR + 1);
  localparam logic [2:0] CODE_MOD = 3'(NPTR + 2);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    if (g < NSH) begin : g_shadowed
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ptr_q[g] <= '0;
          shd_q[g] <= '0;
        end else if (swap) begin
          ptr_q[g] <= shd_q[g];
          shd_q[g] <= ptr_q[g];
        end else if (wr_en && wr_sel == 3'(g)) begin
          ptr_q[g] <= wr_data;
        end else if (upd_en[g]) begin
          ptr_q[g] <= upd_val[g];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            ptr_q[g] <= '0;
        else if (wr_en && wr_sel == 3'(g))     ptr_q[g] <= wr_data;
        else if (upd_en[g])                    ptr_q[g] <= upd_val[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      n3_q  <= '0;
      m01_q <= '1;
    end else if (wr_en) begin
      if (wr_sel == CODE_N)   n_q   <= wr_data;
      if (wr_sel == CODE_N3)  n3_q  <= wr_data;
      if (wr_sel == CODE_MOD) m01_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel < 3'(NPTR))       rd_data = ptr_q[rd_sel[$clog2(NPTR)-1:0]];
    else if (rd_sel == CODE_N)   rd_data = n_q;
    else if (rd_sel == CODE_N3)  rd_data = n3_q;
    else if (rd_sel == CODE_MOD) rd_data = m01_q;
  end
endmodule

// File: rtl/agu_pri_path.sv
module agu_pri_path
  import agu_pkg::*;
#(
  parameter int NPTR    = 4,
  parameter int NSH     = 2,
  parameter int SHORT_W = 6,
  localparam int SW     = $clog2(NPTR)
) (
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_mode,
  input  logic [SW-1:0]    cmd_sel,
  input  addr_t            cmd_disp,
  input  addr_t [NPTR-1:0] ptr_q,
  input  addr_t            n_q,
  input  addr_t            n3_q,
  input  addr_t            m01_q,
  output addr_t            ea,
  output logic             ea_ok,
  output logic             bad_mode,
  output logic             upd,
  output addr_t            upd_val
);
  addr_t cur, addr, nxt;
  logic  lin, post, fmt_ok;

  always_comb begin
    cur    = ptr_q[cmd_sel];
    lin    = !((32'(cmd_sel) < NSH) && (m01_q != '1));
    fmt_ok = (cmd_mode <= MODE_PN3) &&
             !(cmd_mode == MODE_PN3 && cmd_sel != SW'(NPTR - 1));
    addr = cur;
    nxt  = cur;
    post = 1'b0;
    case (cmd_mode)
      MODE_PINC: begin post = 1'b1; nxt = ptr_step(cur, addr_t'(1), lin, m01_q); end
      MODE_PDEC: begin post = 1'b1; nxt = ptr_step(cur, '1, lin, m01_q); end
      MODE_PN:   begin post = 1'b1; nxt = ptr_step(cur, n_q, lin, m01_q); end
      MODE_IDXN: addr = cur + n_q;
      MODE_SHRT: addr = cur + sext_low(cmd_disp, SHORT_W);
      MODE_D16:  addr = cur + sext_low(cmd_disp, 16);
      MODE_D24:  addr = cur + cmd_disp;
      MODE_PN3:  begin post = 1'b1; nxt = cur + n3_q; end
      default:   addr = cur;
    endcase
    ea_ok    = cmd_valid && fmt_ok;
    bad_mode = cmd_valid && !fmt_ok;
    ea       = ea_ok ? addr : '0;
    upd      = ea_ok && post;
    upd_val  = nxt;
  end
endmodule

// File: rtl/agu_sec_path.sv
module agu_sec_path
  import agu_pkg::*;
(
  input  logic  cmd_valid,
  input  logic  cmd_dual,
  input  logic  sec_step_n3,
  input  addr_t r3_q,
  input  addr_t n3_q,
  output addr_t ea_sec,
  output logic  sec_ok,
  output addr_t sec_val
);
  always_comb begin
    sec_ok  = cmd_valid && cmd_dual;
    ea_sec  = sec_ok ? r3_q : '0;
    sec_val = r3_q + (sec_step_n3 ? n3_q : addr_t'(1));
  end
endmodule

// File: rtl/dual_ptr_agu.sv
module dual_ptr_agu
  import agu_pkg::*;
#(
  parameter int SHORT_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd_mode,
  input  logic [1:0]  cmd_sel,
  input  logic [23:0] cmd_disp,
  input  logic        cmd_dual,
  input  logic        sec_step_n3,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [23:0] wr_data,
  input  logic        fi_enter,
  input  logic        fi_exit,
  input  logic [2:0]  rd_sel,
  output logic [23:0] rd_data,
  output logic [23:0] ea_pri,
  output logic        ea_pri_valid,
  output logic [23:0] ea_sec,
  output logic        ea_sec_valid,
  output logic        illegal_mode,
  output logic        dual_conflict
);
  localparam int NPTR = 4;
  localparam int NSH  = 2;
  localparam int LAST = NPTR - 1;

  addr_t [NPTR-1:0] ptr_q;
  addr_t [NSH-1:0]  shd_q;
  addr_t            n_q, n3_q, m01_q;
  logic  [NPTR-1:0] upd_en;
  addr_t [NPTR-1:0] upd_val;
  logic             pri_upd, sec_ok, swap_ev;
  addr_t            pri_val, sec_val;

  assign swap_ev = fi_enter || fi_exit;

  agu_regfile #(.NPTR(NPTR), .NSH(NSH)) u_regs (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_val(upd_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .swap(swap_ev),
    .rd_sel(rd_sel), .ptr_q(ptr_q), .shd_q(shd_q), .n_q(n_q),
    .n3_q(n3_q), .m01_q(m01_q), .rd_data(rd_data)
  );

  agu_pri_path #(.NPTR(NPTR), .NSH(NSH), .SHORT_W(SHORT_W)) u_pri (
    .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .cmd_sel(cmd_sel),
    .cmd_disp(cmd_disp), .ptr_q(ptr_q), .n_q(n_q), .n3_q(n3_q),
    .m01_q(m01_q), .ea(ea_pri), .ea_ok(ea_pri_valid),
    .bad_mode(illegal_mode), .upd(pri_upd), .upd_val(pri_val)
  );

  agu_sec_path u_sec (
    .cmd_valid(cmd_valid), .cmd_dual(cmd_dual), .sec_step_n3(sec_step_n3),
    .r3_q(ptr_q[LAST]), .n3_q(n3_q), .ea_sec(ea_sec), .sec_ok(sec_ok),
    .sec_val(sec_val)
  );

  assign ea_sec_valid  = sec_ok;
  assign dual_conflict = sec_ok && (cmd_sel == 2'(LAST));

  for (genvar g = 0; g < NPTR; g++) begin : g_upd
    if (g == LAST) begin : g_last
      assign upd_en[g]  = sec_ok || (pri_upd && cmd_sel == 2'(g));
      assign upd_val[g] = sec_ok ? sec_val : pri_val;
    end else begin : g_other
      assign upd_en[g]  = pri_upd && cmd_sel == 2'(g);
      assign upd_val[g] = pri_val;
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_mode,
  input logic [1:0]       cmd_sel,
  input logic             cmd_dual,
  input logic             wr_en,
  input logic             swap_ev,
  input logic             ea_pri_valid,
  input logic [AW-1:0]    ea_sec,
  input logic             ea_sec_valid,
  input logic             illegal_mode,
  input logic             dual_conflict,
  input logic [3:0][AW-1:0] ptr_q,
  input logic [1:0][AW-1:0] shd_q
);
  // R3
  idx_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_dual && cmd_mode >= 4'd4 && cmd_mode <= 4'd7 && !wr_en && !swap_ev)
    |=> ptr_q[$past(cmd_sel)] == $past(ptr_q[cmd_sel]));

  // R4
  r2_linear_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_dual && cmd_mode == 4'd1 && cmd_sel == 2'd2 && !wr_en)
    |=> ptr_q[2] == AW'($past(ptr_q[2]) + 1'b1));

  // R6
  sec_from_r3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_sec_valid |-> ea_sec == ptr_q[3]);

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_mode && !cmd_dual && !wr_en && !swap_ev) |=> $stable(ptr_q));

  // R8
  illegal_no_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> !ea_pri_valid);

  // R9
  conflict_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_conflict |-> (ea_sec_valid && cmd_sel == 2'd3));

  // R10
  swap_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ev |=> (ptr_q[0] == $past(shd_q[0]) && shd_q[0] == $past(ptr_q[0]) &&
                 ptr_q[1] == $past(shd_q[1]) && shd_q[1] == $past(ptr_q[1])));
endmodule

bind dual_ptr_agu agu_checker #(.AW(24)) u_agu_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
  .cmd_sel(cmd_sel), .cmd_dual(cmd_dual), .wr_en(wr_en), .swap_ev(swap_ev),
  .ea_pri_valid(ea_pri_valid), .ea_sec(ea_sec), .ea_sec_valid(ea_sec_valid),
  .illegal_mode(illegal_mode), .dual_conflict(dual_conflict),
  .ptr_q(ptr_q), .shd_q(shd_q)
);

// File: tb/dual_ptr_agu_bench.sv
module dual_ptr_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_dual = 0, sec_step_n3 = 0, wr_en = 0;
  logic        fi_enter = 0, fi_exit = 0;
  logic [3:0]  cmd_mode = '0;
  logic [1:0]  cmd_sel = '0;
  logic [23:0] cmd_disp = '0, wr_data = '0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [23:0] rd_data, ea_pri, ea_sec;
  logic        ea_pri_valid, ea_sec_valid, illegal_mode, dual_conflict;

  always #10 clk = ~clk;

  dual_ptr_agu u_dual_ptr_agu (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_sel(cmd_sel), .cmd_disp(cmd_disp), .cmd_dual(cmd_dual),
    .sec_step_n3(sec_step_n3), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .fi_enter(fi_enter), .fi_exit(fi_exit),
    .rd_sel(rd_sel), .rd_data(rd_data), .ea_pri(ea_pri),
    .ea_pri_valid(ea_pri_valid), .ea_sec(ea_sec),
    .ea_sec_valid(ea_sec_valid), .illegal_mode(illegal_mode),
    .dual_conflict(dual_conflict)
  );

  int    n_chk = 0, n_fail = 0, tick = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Behavioural model state
  logic [23:0] mr [4];
  logic [23:0] msh [2];
  logic [23:0] mn, mn3, mm;

  task automatic chk(string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] sx(logic [23:0] v, int w);
    longint t;
    t = longint'(v) & ((64'sd1 <<< w) - 1);
    if (t >= (64'sd1 <<< (w - 1))) t = t - (64'sd1 <<< w);
    return 24'(t);
  endfunction

  function automatic logic [23:0] mstep(logic [23:0] p, int sel, longint d);
    longint pw, sz, off, base;
    if (sel > 1 || mm == 24'hffffff) return 24'(longint'(p) + d);
    pw = 1;
    while (pw < longint'(mm) + 1) pw = pw * 2;
    sz   = longint'(mm) + 1;
    base = longint'(p) - (longint'(p) % pw);
    off  = longint'(p) % pw;
    off  = ((off + d) % sz + sz) % sz;
    return 24'(base + off);
  endfunction

  task automatic cyc(bit v, int mode, int sel, logic [23:0] disp, bit dual,
                     bit sn3, bit we, int ws, logic [23:0] wd, bit fe, bit fx);
    bit legal, post;
    logic [23:0] cur, ea, nxt, rexp;
    logic [23:0] nr [4];
    cmd_valid = v; cmd_mode = 4'(mode); cmd_sel = 2'(sel); cmd_disp = disp;
    cmd_dual = dual; sec_step_n3 = sn3; wr_en = we; wr_sel = 3'(ws);
    wr_data = wd; fi_enter = fe; fi_exit = fx; rd_sel = 3'(tick % 8);
    tick++;
    #8;
    legal = v && mode <= 8 && !(mode == 8 && sel != 3);
    cur = mr[sel]; ea = cur; nxt = cur; post = 0;
    case (mode)
      1: begin post = 1; nxt = mstep(cur, sel, 1); end
      2: begin post = 1; nxt = mstep(cur, sel, -1); end
      3: begin post = 1; nxt = mstep(cur, sel, longint'($signed(mn))); end
      4: ea = cur + mn;
      5: ea = cur + sx(disp, 6);
      6: ea = cur + sx(disp, 16);
      7: ea = cur + disp;
      8: begin post = 1; nxt = cur + mn3; end
      default: ;
    endcase
    chk("ea_pri", ea_pri, legal ? ea : 24'h0);
    chk("ea_pri_valid", 24'(ea_pri_valid), 24'(legal));
    chk("illegal_mode", 24'(illegal_mode), 24'(v && !legal));
    chk("ea_sec", ea_sec, (v && dual) ? mr[3] : 24'h0);
    chk("ea_sec_valid", 24'(ea_sec_valid), 24'(v && dual));
    chk("dual_conflict", 24'(dual_conflict), 24'(v && dual && sel == 3));
    case (rd_sel)
      0, 1, 2, 3: rexp = mr[rd_sel];
      4: rexp = mn;
      5: rexp = mn3;
      6: rexp = mm;
      default: rexp = '0;
    endcase
    chk("rd_data", rd_data, rexp);
    // next state as the clock edge will make it
    for (int i = 0; i < 4; i++) nr[i] = mr[i];
    if (legal && post) nr[sel] = nxt;
    if (v && dual) nr[3] = mr[3] + (sn3 ? mn3 : 24'd1);
    if (we) begin
      if (ws < 4) nr[ws] = wd;
      else if (ws == 4) mn = wd;
      else if (ws == 5) mn3 = wd;
      else if (ws == 6) mm = wd;
    end
    if (fe || fx) begin
      nr[0] = msh[0]; nr[1] = msh[1];
      msh[0] = mr[0]; msh[1] = mr[1];
    end
    for (int i = 0; i < 4; i++) mr[i] = nr[i];
    @(posedge clk); #2;
  endtask

  task automatic op(int mode, int sel, logic [23:0] disp);
    cyc(1, mode, sel, disp, 0, 0, 0, 0, '0, 0, 0);
  endtask
  task automatic wr(int ws, logic [23:0] wd);
    cyc(0, 0, 0, '0, 0, 0, 1, ws, wd, 0, 0);
  endtask
  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mr[i] = '0;
    msh[0] = '0; msh[1] = '0; mn = '0; mn3 = '0; mm = 24'hffffff;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset values across all read codes
    cur_req = "R1"; idle(8);
    // R11: loads and write-over-update priority
    cur_req = "R11";
    wr(0, 24'h000043); wr(1, 24'h000100); wr(2, 24'h002000); wr(3, 24'h003000);
    wr(4, 24'h000003); wr(5, 24'h000010);
    cyc(1, 1, 2, '0, 0, 0, 1, 2, 24'h002222, 0, 0);
    idle(8);
    // R2: address forms on pointer 2
    cur_req = "R2";
    op(0, 2, '0); op(4, 2, '0); op(5, 2, 24'h00003e); op(5, 2, 24'h000005);
    op(6, 2, 24'h00ff00); op(7, 2, 24'h800000); idle(4);
    // R3: post forms on pointer 1 (linear)
    cur_req = "R3";
    op(1, 1, '0); op(1, 1, '0); op(2, 1, '0); op(3, 1, '0); op(4, 1, '0); idle(8);
    // R4: modulo set, pointers 2 and 3 stay linear
    cur_req = "R4";
    wr(6, 24'h000009);
    op(2, 2, '0); op(1, 3, '0); op(3, 2, '0); idle(8);
    // R5: circular buffer of ten words on pointer 0
    cur_req = "R5";
    wr(0, 24'h000049);
    op(1, 0, '0); op(2, 0, '0); op(3, 0, '0);
    wr(4, 24'hfffffc);
    op(3, 0, '0); op(2, 0, '0); op(2, 0, '0); idle(8);
    // R6: dual reads with both secondary steps
    cur_req = "R6";
    cyc(1, 0, 0, '0, 1, 0, 0, 0, '0, 0, 0);
    cyc(1, 1, 1, '0, 1, 1, 0, 0, '0, 0, 0);
    idle(8);
    // R7: N3 post-update on pointer 3
    cur_req = "R7";
    op(8, 3, '0); op(8, 3, '0); idle(8);
    // R8: illegal forms
    cur_req = "R8";
    op(8, 1, '0); op(8, 0, '0); op(12, 2, '0); op(9, 3, '0); idle(8);
    // R9: dual read with pointer 3 as primary
    cur_req = "R9";
    cyc(1, 1, 3, '0, 1, 0, 0, 0, '0, 0, 0);
    cyc(1, 8, 3, '0, 1, 1, 0, 0, '0, 0, 0);
    idle(8);
    // R10: fast-interrupt swaps, competing write dropped
    cur_req = "R10";
    cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 1, 0);
    idle(8);
    cyc(1, 1, 0, '0, 0, 0, 1, 1, 24'h000777, 0, 1);
    idle(8);
    cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 1, 1);
    idle(8);
    // R5 random: keep modulo pointers inside buffers
    cur_req = "R5 random";
    wr(0, 24'h000045); wr(1, 24'h000122);
    cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 1, 0);
    wr(0, 24'h000260); wr(1, 24'h000389); wr(4, 24'h000002);
    for (int i = 0; i < 600; i++) begin
      int kind, ws;
      logic [23:0] wd;
      kind = int'($urandom % 10);
      if (kind == 0) begin
        ws = int'($urandom % 6);
        if (ws < 2)       wd = 24'(($urandom % 512) * 32 + ($urandom % 10));
        else if (ws == 4) wd = 24'(int'($urandom % 17) - 8);
        else              wd = 24'($urandom);
        wr(ws, wd);
      end else begin
        cyc(1, int'($urandom % 10), int'($urandom % 4), 24'($urandom),
            ($urandom % 3) == 0, 1'($urandom), 0, 0, '0,
            ($urandom % 16) == 0, ($urandom % 23) == 0);
      end
    end
    idle(8);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule